// File: doc/BRIEF.md
# Gated Clock Divider Bank

This block takes one fast source clock and produces ten output clocks at a common, lower frequency. Each output can be switched on or off by its own gate. All outputs are derived from a single shared counter, so every enabled output has its rising edge on the same source edge.

The division ratio has two possible sources. The first is a 2-bit strap input that offers four power-of-two ratios. The second is a 4-bit register code that offers twelve ratios, including odd values and even values that are not powers of two. The strap is in control after reset. The first valid register write of a ratio hands control to the register, and control stays there until the next reset.

The register interface is a simple write strobe with an address and data. Every ratio change and every gate change waits for the end of the output period that is in progress. As a result, an output never produces a shortened or runt pulse.

Top module: `clkdiv_bank`

## Requirements
- R1: There are ten outputs. Bit i of the enable register (address 1, data bits 9:0) gates output i, and a 1 lets the output run. After reset the enable register holds all ones, and a disabled output stays low.
- R2: While the override flag is clear, the strap input sets the ratio. Code 0 gives divide-by-2, 1 gives 4, 2 gives 8 and 3 gives 16. The strap is read continuously and is applied at the next period boundary.
- R3: With the strap held at 3, the outputs after reset run at divide-by-16: eight source cycles high, then eight low.
- R4: A write to address 0 takes data bits 3:0 as the ratio code. Codes 0 to 11 select ratios 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 20 and 24, in that order.
- R5: Codes 12 to 15 are reserved. Writing one leaves the ratio and the override flag unchanged.
- R6: Reset clears the override flag. The first valid ratio write sets it, and only reset clears it again. Once it is set, the strap has no effect.
- R7: For ratio N, each output period spans 2N source half-cycles, and the output is high for the first N of them. Odd ratios end their high phase on a falling source edge. Ratio 1 passes the source clock through.
- R8: A new ratio takes effect only on the rising edge that begins a new period. The period in progress finishes at the old ratio.
- R9: A write to the enable register takes effect only at the next period boundary, while the output is low.
- R10: All enabled outputs are identical, cycle for cycle.
- R11: During reset every output is low. The first period starts on the first rising source edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_code | input | 2 | Hardware ratio select, used while the override flag is clear |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge of clk_src |
| wr_addr | input | 2 | Register address: 0 for the ratio code, 1 for the enable mask |
| wr_data | input | 10 | Write data |
| clk_out | output | 10 | Divided, gated output clocks |

## Verification
A write is captured on the first rising edge at which wr_en is seen. It then waits for the next period boundary, which is the rising edge where the count wraps. The outputs change level on the source edges that follow that boundary.

The bench keeps its own count of source cycles and its own copies of the ratio, override flag and enable mask. At each rising edge it first advances the period, using the pending values from before the edge, and only then applies any write seen at that edge. This order mirrors the registered path.

Each output is sampled 2.5 ns after every rising edge and 2.5 ns after every falling edge. The bench compares each sample with the half-cycle position inside the period, so no sample lands on an edge.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int RATIO_W = 5;
  localparam int CODE_W  = 4;
  localparam int STRAP_W = 2;
  localparam int NUM_CODES = 12;

  typedef logic [RATIO_W-1:0] ratio_t;

  // Power-of-two ratio picked by the strap pins.
  function automatic ratio_t strap_ratio(input logic [STRAP_W-1:0] code);
    return ratio_t'(2) << code;
  endfunction

  function automatic logic reg_code_ok(input logic [CODE_W-1:0] code);
    return code < CODE_W'(NUM_CODES);
  endfunction

  function automatic ratio_t reg_ratio(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    return ratio_t'(1);
      4'd1:    return ratio_t'(2);
      4'd2:    return ratio_t'(3);
      4'd3:    return ratio_t'(4);
      4'd4:    return ratio_t'(5);
      4'd5:    return ratio_t'(6);
      4'd6:    return ratio_t'(8);
      4'd7:    return ratio_t'(10);
      4'd8:    return ratio_t'(12);
      4'd9:    return ratio_t'(16);
      4'd10:   return ratio_t'(20);
      default: return ratio_t'(24);
    endcase
  endfunction

  // Number of whole source cycles the rising-edge phase stays high.
  function automatic ratio_t high_cycles(input ratio_t n);
    return n >> 1;
  endfunction
endpackage

// File: rtl/clkdiv_cfg.sv
`timescale 1ns/1ps
module clkdiv_cfg
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT    = 10,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 10,
  parameter int ADDR_RATIO = 0,
  parameter int ADDR_EN    = 1
) (
  input  logic                clk_src,
  input  logic                rst_n,
  input  logic [STRAP_W-1:0]  strap_code,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output ratio_t              ratio_next,
  output logic [NUM_OUT-1:0]  en_next,
  output logic                override,
  output logic                ratio_wr_ok
);
  logic [CODE_W-1:0] code_q;
  logic              ratio_sel;
  logic              en_sel;

  assign ratio_sel   = wr_en && (wr_addr == ADDR_W'(ADDR_RATIO));
  assign en_sel      = wr_en && (wr_addr == ADDR_W'(ADDR_EN));
  assign ratio_wr_ok = ratio_sel && reg_code_ok(wr_data[CODE_W-1:0]);

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      override <= 1'b0;
      en_next  <= '1;
    end else begin
      if (ratio_wr_ok) begin
        code_q   <= wr_data[CODE_W-1:0];
        override <= 1'b1;
      end
      if (en_sel) en_next <= wr_data[NUM_OUT-1:0];
    end
  end

  assign ratio_next = override ? reg_ratio(code_q) : strap_ratio(strap_code);
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic   clk_src,
  input  logic   rst_n,
  input  ratio_t ratio_next,
  output logic   tc,
  output ratio_t ratio_cur,
  output logic   wave
);
  ratio_t cnt;
  ratio_t cnt_nx;
  ratio_t ratio_nx;
  logic   rise_ph;
  logic   fall_ph;

  assign tc       = (cnt == ratio_cur - ratio_t'(1));
  assign cnt_nx   = tc ? '0 : cnt + ratio_t'(1);
  assign ratio_nx = tc ? ratio_next : ratio_cur;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      ratio_cur <= ratio_t'(1);
      rise_ph   <= 1'b0;
    end else begin
      cnt       <= cnt_nx;
      ratio_cur <= ratio_nx;
      rise_ph   <= cnt_nx < high_cycles(ratio_nx);
    end
  end

  // Half-cycle extension for odd ratios.
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) fall_ph <= 1'b0;
    else        fall_ph <= rise_ph;
  end

  always_comb begin
    if (ratio_cur == ratio_t'(1)) wave = clk_src;
    else if (ratio_cur[0])        wave = rise_ph | fall_ph;
    else                          wave = rise_ph;
  end
endmodule

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate #(
  parameter int NUM_OUT = 10
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic               tc,
  input  logic               wave,
  input  logic [NUM_OUT-1:0] en_next,
  output logic [NUM_OUT-1:0] en_act,
  output logic [NUM_OUT-1:0] clk_out
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n)  en_act[i] <= 1'b0;
      else if (tc) en_act[i] <= en_next[i];
    end
    assign clk_out[i] = wave & en_act[i];
  end
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT    = 10,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 10,
  parameter int ADDR_RATIO = 0,
  parameter int ADDR_EN    = 1
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic [1:0]         strap_code,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_OUT-1:0] clk_out
);
  ratio_t             ratio_next_w;
  ratio_t             ratio_cur_w;
  logic [NUM_OUT-1:0] en_next_w;
  logic [NUM_OUT-1:0] en_act_w;
  logic               override_w;
  logic               ratio_wr_ok_w;
  logic               tc_w;
  logic               wave_w;

  clkdiv_cfg #(
    .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_RATIO(ADDR_RATIO), .ADDR_EN(ADDR_EN)
  ) u_cfg (
    .clk_src(clk_src), .rst_n(rst_n), .strap_code(strap_code),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ratio_next(ratio_next_w), .en_next(en_next_w),
    .override(override_w), .ratio_wr_ok(ratio_wr_ok_w)
  );

  clkdiv_core u_core (
    .clk_src(clk_src), .rst_n(rst_n), .ratio_next(ratio_next_w),
    .tc(tc_w), .ratio_cur(ratio_cur_w), .wave(wave_w)
  );

  clkdiv_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .clk_src(clk_src), .rst_n(rst_n), .tc(tc_w), .wave(wave_w),
    .en_next(en_next_w), .en_act(en_act_w), .clk_out(clk_out)
  );
endmodule

// File: rtl/clkdiv_bank_chk.sv
`timescale 1ns/1ps
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT    = 10,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 10,
  parameter int ADDR_RATIO = 0
) (
  input logic               clk_src,
  input logic               rst_n,
  input logic               tc,
  input ratio_t             ratio_cur,
  input logic [NUM_OUT-1:0] en_act,
  input logic               override,
  input logic               ratio_wr_ok,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data
);
  // R8
  ratio_hold_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    !tc |=> $stable(ratio_cur));

  // R9
  gate_hold_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    !tc |=> $stable(en_act));

  // R6
  override_sticky_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    override |=> override);

  // R6
  override_set_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    ratio_wr_ok |=> override);

  // R5
  reserved_ignored_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADDR_RATIO) && wr_data[3:0] >= 4'd12 && !override)
      |=> !override);

  // R4
  ratio_legal_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (ratio_cur != '0) && (ratio_cur <= ratio_t'(24)));
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
  .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_RATIO(ADDR_RATIO)
) u_chk (
  .clk_src(clk_src), .rst_n(rst_n), .tc(tc_w), .ratio_cur(ratio_cur_w),
  .en_act(en_act_w), .override(override_w), .ratio_wr_ok(ratio_wr_ok_w),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/clkdiv_bank_tb.sv
`timescale 1ns/1ps
module clkdiv_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap = 2'd3;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic [9:0] clk_out;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R11";

  // bench model
  int       m_cnt = 0;
  int       m_n = 1;
  logic [9:0] m_gate = '0;
  logic [9:0] m_mask = '1;
  logic     m_ovr = 1'b0;
  int       m_code = 0;

  always #5 clk = ~clk;

  clkdiv_bank u_dut (
    .clk_src(clk), .rst_n(rst_n), .strap_code(strap),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .clk_out(clk_out)
  );

  function automatic int pin_div(input int s);
    int d = 1;
    for (int k = 0; k <= s; k++) d = d * 2;
    return d;
  endfunction

  function automatic int code_div(input int c);
    int tbl [12] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 20, 24};
    return tbl[c];
  endfunction

  function automatic logic [9:0] expect_out(input int half);
    return (half < m_n) ? m_gate : 10'h000;
  endfunction

  task automatic check(input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", cur_req, $time, got, exp);
    end
  endtask

  // Model steps at each rising edge, then checks both half-cycles.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_n = 1; m_gate = '0; m_mask = '1; m_ovr = 1'b0; m_code = 0;
    end else begin
      if (m_cnt == m_n - 1) begin
        m_cnt  = 0;
        m_n    = m_ovr ? code_div(m_code) : pin_div(int'(strap));
        m_gate = m_mask;
      end else begin
        m_cnt++;
      end
      if (wr_en && wr_addr == 2'd0 && wr_data[3:0] < 4'd12) begin
        m_code = int'(wr_data[3:0]);
        m_ovr  = 1'b1;
      end
      if (wr_en && wr_addr == 2'd1) m_mask = wr_data;
    end
    #2.5 check(clk_out, expect_out(2 * m_cnt));
    #5   check(clk_out, expect_out(2 * m_cnt + 1));
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    cur_req = "R11 reset low";
    wait_cyc(5);
    rst_n = 1'b1;

    cur_req = "R3 R7 R10 default divide-by-16";
    wait_cyc(40);

    cur_req = "R2 R8 strap ratios";
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); strap = 2'(s);
      wait_cyc(40);
    end

    cur_req = "R5 R6 reserved code before override";
    reg_write(2'd0, 10'd14);
    @(negedge clk); strap = 2'd0;
    wait_cyc(20);

    cur_req = "R4 R7 R6 register ratio table";
    for (int c = 0; c < 12; c++) begin
      reg_write(2'd0, 10'(c));
      wait_cyc(3 * code_div(c) + 30);
    end
    cur_req = "R6 strap ignored after override";
    @(negedge clk); strap = 2'd1;
    wait_cyc(60);

    cur_req = "R5 reserved code after override";
    reg_write(2'd0, 10'd2);
    wait_cyc(12);
    reg_write(2'd0, 10'd12);
    wait_cyc(12);
    reg_write(2'd0, 10'd15);
    wait_cyc(12);

    cur_req = "R1 R9 R10 output gates";
    reg_write(2'd0, 10'd9);
    wait_cyc(5);
    reg_write(2'd1, 10'h2A5);
    wait_cyc(50);
    reg_write(2'd1, 10'h000);
    wait_cyc(40);
    reg_write(2'd1, 10'h3FF);
    wait_cyc(40);

    cur_req = "R8 mid-period ratio change";
    reg_write(2'd0, 10'd11);
    wait_cyc(30);
    reg_write(2'd0, 10'd2);
    wait_cyc(3);
    reg_write(2'd0, 10'd0);
    wait_cyc(20);

    cur_req = "R1 R4 R5 R9 random mix";
    for (int it = 0; it < 60; it++) begin
      case ($urandom_range(3, 0))
        0: reg_write(2'd0, 10'($urandom_range(11, 0)));
        1: reg_write(2'd0, 10'($urandom_range(15, 12)));
        2: reg_write(2'd1, 10'($urandom_range(1023, 0)));
        default: begin @(negedge clk); strap = 2'($urandom_range(3, 0)); end
      endcase
      wait_cyc($urandom_range(60, 1));
    end

    cur_req = "R11 reset again";
    @(negedge clk); rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    cur_req = "R2 R3 strap control after reset";
    wait_cyc(40);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule